// File: doc/BRIEF.md
# Masked Time Alarm Interrupt Controller

This block holds two time-of-day/date alarms for a real-time clock that counts in BCD. Each alarm has four compare bytes: seconds, minutes, hours and day. The most significant bit of each byte is a mask that removes that field from the comparison. The lower seven bits are compared with the matching live time field. Once per second, on the tick pulse, every alarm is evaluated. An alarm whose unmasked fields all match sets its sticky status flag.

The mask bits turn one alarm into a periodic one. With all four masked it fires every second. With only seconds unmasked it fires once a minute. Unmasking minutes as well gives once an hour, and unmasking hours gives once a day. A flag is set whether or not its interrupt is enabled. A control byte holds one interrupt enable per alarm and a routing bit. The routing bit either merges both alarms onto interrupt line 0 or gives each alarm its own line. Software pulses a clear input to drop a flag and keep the alarm armed. It clears the enable to silence the alarm's output for good.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: After a synchronous reset the flags, both interrupt lines, the enables and the routing bit are all 0. Every alarm byte resets to 00h.
- R2: Alarm byte addresses are as follows. Alarm 0 uses 7, 8, 9 and 10, and alarm 1 uses 11, 12, 13 and 14, each in the order seconds, minutes, hours, day. With every mask bit (bit 7) at 0, a tick sets the flag only when all four 7-bit fields equal the live time.
- R3: With all four mask bits of an alarm at 1, every tick sets that alarm's flag.
- R4: A masked field is left out of the comparison. With only the seconds byte unmasked, a tick sets the flag whenever the seconds match, whatever the other fields hold.
- R5: A matching tick sets the flag even when the alarm's interrupt enable is 0, and no interrupt line rises.
- R6: The control byte is written at address 15. Bit 0 enables alarm 0 and bit 1 enables alarm 1. When a flag and its enable are both 1, the routed interrupt line is 1 one cycle after the flag.
- R7: Routing is set by bit 2 of the control byte. With bit 2 at 0, both alarms drive line 0 and line 1 stays 0. With bit 2 at 1, alarm 0 drives line 0 and alarm 1 drives line 1.
- R8: A clear pulse on bit i of flag_clr_i drops flag i on the next edge, and its interrupt falls one cycle later. The next matching tick sets the flag and the interrupt again.
- R9: Writing the enable to 0 drops the interrupt. Later matches still set the flag but no longer raise the line.
- R10: Without a tick, no flag is set, even while the live time matches.
- R11: When a tick matches in the same cycle as a clear of that flag, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| sec_i | input | 7 | Live seconds, BCD |
| min_i | input | 7 | Live minutes, BCD |
| hour_i | input | 7 | Live hours, BCD including mode bits |
| day_i | input | 7 | Live day field, BCD |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 8 | Register write data |
| flag_clr_i | input | 2 | Per-alarm flag clear pulses |
| flags_o | output | 2 | Sticky alarm flags |
| irq_o | output | 2 | Interrupt lines 0 and 1 |

## Verification
The bench checks a full match against near misses in a single field. A comparator that ignored one field would set a flag on those misses. It holds a matching time with no tick to catch logic that sets flags every cycle. It also compares a flag clear with an enable clear: the first must re-arm the alarm, and the second must leave the flag setting but the line quiet. Two further cases are a clear arriving in the same cycle as a matching tick, which the clear must not win, and both routing settings, where a wrong mux would send alarm 1 to the wrong line or to neither.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int NUM_FIELDS = 4;
  localparam int TIME_W     = 7;
  localparam int BYTE_W     = 8;
  localparam int MASK_BIT   = 7;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/alm_regs.sv
module alm_regs
  import alm_pkg::*;
#(
  parameter int NUM_ALARMS = 2,
  parameter int ADDR_W     = 4,
  parameter int BASE_ADDR  = 7
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 wr_en,
  input  logic [ADDR_W-1:0]                    wr_addr,
  input  byte_t                                wr_data,
  output logic [NUM_ALARMS*NUM_FIELDS*BYTE_W-1:0] alarm_bytes,
  output logic [NUM_ALARMS-1:0]                irq_en,
  output logic                                 route_sel
);
  localparam int NUM_REGS  = NUM_ALARMS * NUM_FIELDS;
  localparam int CTRL_ADDR = BASE_ADDR + NUM_REGS;

  // one byte register per compare field of every alarm
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    byte_t q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (wr_en && wr_addr == ADDR_W'(BASE_ADDR + r)) q <= wr_data;
    end
    assign alarm_bytes[r*BYTE_W +: BYTE_W] = q;
  end

  // control: enables in the low bits, routing just above them
  logic [NUM_ALARMS:0] ctrl_q;
  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (wr_en && wr_addr == ADDR_W'(CTRL_ADDR)) ctrl_q <= wr_data[NUM_ALARMS:0];
  end

  assign irq_en    = ctrl_q[NUM_ALARMS-1:0];
  assign route_sel = ctrl_q[NUM_ALARMS];
endmodule

// File: rtl/alm_match.sv
module alm_match
  import alm_pkg::*;
(
  input  logic [NUM_FIELDS*BYTE_W-1:0] cmp_bytes,
  input  logic [NUM_FIELDS*TIME_W-1:0] now,
  output logic                         hit
);
  logic [NUM_FIELDS-1:0] field_ok;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    assign field_ok[f] = cmp_bytes[f*BYTE_W + MASK_BIT] |
                         (cmp_bytes[f*BYTE_W +: TIME_W] == now[f*TIME_W +: TIME_W]);
  end

  assign hit = &field_ok;
endmodule

// File: rtl/alm_flags_irq.sv
module alm_flags_irq #(
  parameter int NUM_ALARMS = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick,
  input  logic [NUM_ALARMS-1:0] hit,
  input  logic [NUM_ALARMS-1:0] clr,
  input  logic [NUM_ALARMS-1:0] irq_en,
  input  logic                  route_sel,
  output logic [NUM_ALARMS-1:0] flags,
  output logic [NUM_ALARMS-1:0] irq
);
  logic [NUM_ALARMS-1:0] set_v, live, irq_d;

  assign set_v = tick ? hit : '0;

  // sticky flags: a new match outranks a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~clr) | set_v;
  end

  assign live = flags & irq_en;

  always_comb begin
    if (route_sel) begin
      irq_d = live;
    end else begin
      irq_d    = '0;
      irq_d[0] = |live;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= '0;
    else     irq <= irq_d;
  end
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
  import alm_pkg::*;
#(
  parameter int NUM_ALARMS = 2,
  parameter int ADDR_W     = 4,
  parameter int BASE_ADDR  = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick_i,
  input  logic [TIME_W-1:0]     sec_i,
  input  logic [TIME_W-1:0]     min_i,
  input  logic [TIME_W-1:0]     hour_i,
  input  logic [TIME_W-1:0]     day_i,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [BYTE_W-1:0]     wr_data_i,
  input  logic [NUM_ALARMS-1:0] flag_clr_i,
  output logic [NUM_ALARMS-1:0] flags_o,
  output logic [NUM_ALARMS-1:0] irq_o
);
  localparam int SET_W = NUM_FIELDS * BYTE_W;

  logic [NUM_ALARMS*SET_W-1:0]   alarm_bytes;
  logic [NUM_ALARMS-1:0]         irq_en;
  logic                          route_sel;
  logic [NUM_ALARMS-1:0]         hit;
  logic [NUM_FIELDS*TIME_W-1:0]  now;

  assign now = {day_i, hour_i, min_i, sec_i};

  alm_regs #(
    .NUM_ALARMS(NUM_ALARMS), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
    .alarm_bytes(alarm_bytes), .irq_en(irq_en), .route_sel(route_sel)
  );

  for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alarm
    alm_match u_match (
      .cmp_bytes(alarm_bytes[a*SET_W +: SET_W]),
      .now(now),
      .hit(hit[a])
    );
  end

  alm_flags_irq #(.NUM_ALARMS(NUM_ALARMS)) u_flags (
    .clk(clk), .rst(rst), .tick(tick_i), .hit(hit), .clr(flag_clr_i),
    .irq_en(irq_en), .route_sel(route_sel), .flags(flags_o), .irq(irq_o)
  );
endmodule

// File: rtl/alarm_irq_ctrl_chk.sv
module alarm_irq_ctrl_chk #(
  parameter int NUM_ALARMS = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  tick,
  input logic [NUM_ALARMS-1:0] clr,
  input logic [NUM_ALARMS-1:0] en,
  input logic                  route,
  input logic [NUM_ALARMS-1:0] flags,
  input logic [NUM_ALARMS-1:0] irq
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (flags == '0 && irq == '0));

  a_r10_set_needs_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ((flags & ~$past(flags)) == '0));

  a_r8_clear_drops_flag: assert property (@(posedge clk) disable iff (rst)
    (!tick && clr != '0) |=> ((flags & $past(clr)) == '0));

  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |=> (irq == '0));

  a_r7_merged_line1_low: assert property (@(posedge clk) disable iff (rst)
    !route |=> (irq[NUM_ALARMS-1:1] == '0));

  a_r6_enabled_flag_raises: assert property (@(posedge clk) disable iff (rst)
    ((flags & en) != '0) |=> (irq != '0));
endmodule

bind alarm_irq_ctrl alarm_irq_ctrl_chk #(.NUM_ALARMS(NUM_ALARMS)) u_chk (
  .clk(clk), .rst(rst), .tick(tick_i), .clr(flag_clr_i), .en(irq_en),
  .route(route_sel), .flags(flags_o), .irq(irq_o)
);

// File: tb/alarm_irq_ctrl_bench.sv
module alarm_irq_ctrl_bench;
  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;  // 50 MHz

  logic       tick_i = 0, wr_en_i = 0;
  logic [6:0] sec_i = 0, min_i = 0, hour_i = 0, day_i = 0;
  logic [3:0] wr_addr_i = 0;
  logic [7:0] wr_data_i = 0;
  logic [1:0] flag_clr_i = 0;
  logic [1:0] flags_o, irq_o;

  alarm_irq_ctrl u_alarm_irq_ctrl (.*);

  typedef struct { logic [1:0] fl; logic [1:0] ir; string tag; } exp_t;
  exp_t q[$];

  int total = 0, fails = 0;
  bit done = 0;

  // requirement model
  logic [7:0] m_alm [2][4];
  logic [1:0] m_flags = 0, m_en = 0, m_irq = 0;
  logic       m_route = 0;
  logic [6:0] cs = 0, cm = 0, ch = 0, cd = 0;

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp, input string what);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input bit tk, input logic [6:0] s, m, h, d,
                     input bit we, input logic [3:0] a, input logic [7:0] dt,
                     input logic [1:0] clr, input string tag);
    logic [1:0] live, nirq, hit, nfl;
    logic [6:0] t [4];
    @(negedge clk);
    tick_i = tk; sec_i = s; min_i = m; hour_i = h; day_i = d;
    wr_en_i = we; wr_addr_i = a; wr_data_i = dt; flag_clr_i = clr;
    t[0] = s; t[1] = m; t[2] = h; t[3] = d;
    live = m_flags & m_en;
    nirq = m_route ? live : {1'b0, |live};
    for (int i = 0; i < 2; i++) begin
      hit[i] = 1'b1;
      for (int f = 0; f < 4; f++)
        if (!m_alm[i][f][7] && m_alm[i][f][6:0] != t[f]) hit[i] = 1'b0;
    end
    nfl = (m_flags & ~clr) | (tk ? hit : 2'b00);
    if (we) begin
      if (a >= 7 && a <= 14) m_alm[(a-7)/4][(a-7)%4] = dt;
      else if (a == 15) begin m_en = dt[1:0]; m_route = dt[2]; end
    end
    m_flags = nfl; m_irq = nirq;
    q.push_back('{m_flags, m_irq, tag});
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] dt, input string tag);
    cyc(0, cs, cm, ch, cd, 1, a, dt, 0, tag);
  endtask
  task automatic idle(input string tag);
    cyc(0, cs, cm, ch, cd, 0, 0, 0, 0, tag);
  endtask
  task automatic clr(input logic [1:0] c, input string tag);
    cyc(0, cs, cm, ch, cd, 0, 0, 0, c, tag);
  endtask
  task automatic tk(input logic [6:0] s, m, h, d, input string tag);
    cs = s; cm = m; ch = h; cd = d;
    cyc(1, s, m, h, d, 0, 0, 0, 0, tag);
  endtask

  // monitor: pops one expected item per edge
  always @(posedge clk) begin
    exp_t e;
    #5;
    if (q.size() > 0) begin
      e = q.pop_front();
      check(e.tag, flags_o, e.fl, "flags");
      check(e.tag, irq_o, e.ir, "irq");
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) for (int f = 0; f < 4; f++) m_alm[i][f] = 8'h00;
    repeat (3) @(posedge clk);
    #5;
    check("R1", flags_o, 2'b00, "reset flags");
    check("R1", irq_o, 2'b00, "reset irq");
    @(negedge clk); rst = 0;

    // R2: alarm 0 = 08:15:30 day 3, no masks
    wr(7, 8'h30, "R2"); wr(8, 8'h15, "R2"); wr(9, 8'h08, "R2"); wr(10, 8'h03, "R2");
    tk(7'h31, 7'h15, 7'h08, 7'h03, "R2");
    tk(7'h30, 7'h16, 7'h08, 7'h03, "R2");
    tk(7'h30, 7'h15, 7'h09, 7'h03, "R2");
    tk(7'h30, 7'h15, 7'h08, 7'h04, "R2");
    tk(7'h30, 7'h15, 7'h08, 7'h03, "R2");
    idle("R5"); idle("R5");
    // R10: hold matching time without a tick
    clr(2'b01, "R10"); idle("R10"); idle("R10");
    // R6: enable alarm 0
    wr(15, 8'h01, "R6"); idle("R6");
    tk(7'h30, 7'h15, 7'h08, 7'h03, "R6"); idle("R6"); idle("R6");
    // R8: flag clear re-arms
    clr(2'b01, "R8"); idle("R8"); idle("R8");
    tk(7'h30, 7'h15, 7'h08, 7'h03, "R8"); idle("R8"); idle("R8");
    // R9: enable clear silences
    wr(15, 8'h00, "R9"); idle("R9"); clr(2'b01, "R9");
    tk(7'h30, 7'h15, 7'h08, 7'h03, "R9"); idle("R9"); idle("R9");
    clr(2'b01, "R9");
    // R3: alarm 1 fully masked
    wr(11, 8'h80, "R3"); wr(12, 8'h80, "R3"); wr(13, 8'h80, "R3"); wr(14, 8'h80, "R3");
    tk(7'h01, 7'h02, 7'h03, 7'h04, "R3"); clr(2'b10, "R3");
    tk(7'h59, 7'h59, 7'h23, 7'h07, "R3"); idle("R3");
    // R7: routing
    wr(15, 8'h02, "R7"); idle("R7"); idle("R7");
    wr(15, 8'h06, "R7"); idle("R7"); idle("R7");
    wr(15, 8'h07, "R7"); clr(2'b01, "R7");
    tk(7'h30, 7'h15, 7'h08, 7'h03, "R7"); idle("R7"); idle("R7");
    wr(15, 8'h03, "R7"); idle("R7"); idle("R7");
    wr(15, 8'h00, "R7"); clr(2'b11, "R7"); idle("R7");
    // R4: only seconds unmasked on alarm 1
    wr(11, 8'h45, "R4");
    tk(7'h44, 7'h10, 7'h11, 7'h05, "R4"); idle("R4");
    tk(7'h45, 7'h10, 7'h11, 7'h05, "R4"); clr(2'b10, "R4");
    tk(7'h45, 7'h59, 7'h23, 7'h07, "R4"); clr(2'b10, "R4");
    // R11: set beats a same-cycle clear
    cs = 7'h45;
    cyc(1, 7'h45, 7'h00, 7'h00, 7'h01, 0, 0, 0, 2'b10, "R11");
    idle("R11"); idle("R11");

    repeat (3) @(posedge clk);
    #6;
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule